// File: doc/BRIEF.md
# Fixed-Slot Shared Memory Arbiter

This block gives eight requesters access to one shared 32 KB memory through a fixed time-division rotation. A free-running phase counter cycles through sixteen values. Requester i owns the memory only when the phase equals 2*i. The odd phases belong to nobody. A requester raises a request with a direction, an access size, a byte address and write data. It holds that request until it is acknowledged. The access is carried out at the requester's own phase. The acknowledge and the read data appear in the following cycle.

A slot whose owner has no request leaves the memory idle. It is never handed to a waiting neighbour. As a result, the wait a requester sees depends only on the phase at which it asks, not on how busy the other seven are. A loop that repeats with a period of exactly one rotation sees the same wait on every pass.

Accesses are byte, 16-bit word or 32-bit long. The block works out the byte lanes from the size and the low address bits. It places write data into those lanes and returns read data right-justified.

Top module: `slot_mem_arbiter`

## Requirements
- R1: While reset is high, `ack` is all zero. The rotation phase is 0 at the first rising edge with reset low, and it advances by one, modulo 16, on every later edge.
- R2: A request from requester i held from phase p is carried out at the edge where the phase equals 2*i. `ack[i]` and `rdata` become visible in the cycle after that edge, so the latency in cycles is ((2*i - p) mod 16) + 1.
- R3: At most one bit of `ack` is high in any cycle, and no access ever happens at an odd phase.
- R4: The latency of a requester for a given start phase is identical whether it is the only active requester or all eight request at once.
- R5: A slot whose owner is not requesting is left unused, even when other requesters are waiting. A request raised just after the owner's slot waits a full 16 cycles.
- R6: A request reissued exactly one rotation (16 cycles) after the previous one was issued is acknowledged with the same latency every time.
- R7: `req_size` encodes 0 = byte, 1 = 16-bit word, 2 or 3 = 32-bit long. A write changes only the addressed byte lanes of the long that holds it, and leaves every other byte unchanged.
- R8: Addresses are byte addresses over 32 KB. A long access ignores address bits 1:0, and a word access ignores address bit 0.
- R9: Write data is taken from the low bits of `req_wdata`, and higher bits are ignored. Read data is returned right-justified and zero-extended for byte and word accesses.
- R10: A requester whose request stays high receives one acknowledge per rotation: `ack[i]` is never high in two consecutive cycles, and successive acknowledges are 16 cycles apart.
- R11: Memory contents are shared: data written by one requester is read back unchanged by any other requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Request pending, one bit per requester |
| req_write | input | 8 | 1 = write, 0 = read, per requester |
| req_size | input | 16 | Access size, 2 bits per requester (0 byte, 1 word, 2/3 long) |
| req_addr | input | 120 | Byte address, 15 bits per requester |
| req_wdata | input | 256 | Write data, 32 bits per requester, right-justified |
| ack | output | 8 | Access done, one bit per requester, one cycle after its slot |
| rdata | output | 32 | Read data for the acknowledged requester, right-justified |

## Verification
The behaviour hardest to show is that a requester's latency stays the same whether or not the others are busy. Per-phase behaviour alone does not prove this. The stimulus therefore sweeps requester 3 through all sixteen start phases twice: once alone, and once with all eight requesters raising reads at that same phase. The bench compares the two latencies directly and counts any cycle with more than one acknowledge. A held request and a request raised just past its own slot are driven separately to expose any slot reuse or double grant.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int ADDR_W = 15;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              wr;
        acc_size_e         size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_cmd_t;

    function automatic logic [OFF_W-1:0] lane_offset(acc_size_e sz, logic [OFF_W-1:0] low);
        case (sz)
            SZ_BYTE: return low;
            SZ_WORD: return {low[OFF_W-1], 1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFF_W-1:0] off);
        case (sz)
            SZ_BYTE: return LANES'(4'b0001) << off;
            SZ_WORD: return LANES'(4'b0011) << off;
            default: return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] place_data(logic [DATA_W-1:0] d, logic [OFF_W-1:0] off);
        return d << {off, 3'b000};
    endfunction

    function automatic logic [DATA_W-1:0] pick_data(acc_size_e sz, logic [DATA_W-1:0] w,
                                                    logic [OFF_W-1:0] off);
        logic [DATA_W-1:0] s;
        s = w >> {off, 3'b000};
        case (sz)
            SZ_BYTE: return s & DATA_W'(32'h0000_00FF);
            SZ_WORD: return s & DATA_W'(32'h0000_FFFF);
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/slot_rotor.sv
module slot_rotor #(
    parameter int PERIOD = 16,
    localparam int SLOT_W = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] phase
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assert_start_zero_R1: assert property (@(posedge clk)
        disable iff (rst) $past(rst) |-> phase == '0);

    assert_advance_R1: assert property (@(posedge clk)
        disable iff (rst) (!$past(rst) && $past(phase) != LAST) |-> phase == $past(phase) + 1'b1);

endmodule

// File: rtl/slot_picker.sv
module slot_picker
    import slot_arb_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int SLOT_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLOT_W-1:0]  phase,
    input  logic [NUM_REQ-1:0] req_valid,
    input  mem_cmd_t           cmds [NUM_REQ],
    output logic               mem_en,
    output mem_cmd_t           mem_cmd,
    output logic [NUM_REQ-1:0] ack
);
    logic [NUM_REQ-1:0] hit;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_own
        assign hit[i] = req_valid[i] && (phase == SLOT_W'(2 * i));
    end

    always_comb begin
        mem_en  = |hit;
        mem_cmd = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (hit[i]) mem_cmd = cmds[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ack <= '0;
        else     ack <= hit;
    end

    assert_single_grant_R3: assert property (@(posedge clk)
        disable iff (rst) $onehot0(ack));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
        assert_slot_origin_R2: assert property (@(posedge clk)
            disable iff (rst) ack[i] |-> ($past(phase) == SLOT_W'(2 * i) && $past(req_valid[i])));
        assert_once_per_turn_R10: assert property (@(posedge clk)
            disable iff (rst) ack[i] |=> !ack[i]);
    end

endmodule

// File: rtl/shared_ram.sv
module shared_ram
    import slot_arb_pkg::*;
#(
    parameter int BYTES = 32768,
    localparam int DEPTH = BYTES / LANES,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  mem_cmd_t          cmd,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] word_q;
    logic [OFF_W-1:0]  off_q;
    acc_size_e         size_q;

    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] wd;

    always_comb begin
        idx = cmd.addr[OFF_W +: IDX_W];
        off = lane_offset(cmd.size, cmd.addr[OFF_W-1:0]);
        be  = lane_mask(cmd.size, off);
        wd  = place_data(cmd.wdata, off);
    end

    always_ff @(posedge clk) begin
        if (en) begin
            if (cmd.wr) begin
                for (int l = 0; l < LANES; l++) begin
                    if (be[l]) mem[idx][8*l +: 8] <= wd[8*l +: 8];
                end
            end
            word_q <= mem[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            size_q <= SZ_LONG;
        end else if (en) begin
            off_q  <= off;
            size_q <= cmd.size;
        end
    end

    assign rdata = pick_data(size_q, word_q, off_q);

    assert_lane_span_R7: assert property (@(posedge clk)
        disable iff (rst) en |-> ($countones(be) == 1 || $countones(be) == 2 || $countones(be) == 4));

endmodule

// File: rtl/slot_mem_arbiter.sv
module slot_mem_arbiter
    import slot_arb_pkg::*;
#(
    parameter int NUM_REQ = 8,
    localparam int PERIOD = 2 * NUM_REQ,
    localparam int SLOT_W = $clog2(PERIOD),
    localparam int BYTES  = 1 << ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_REQ-1:0]          req_valid,
    input  logic [NUM_REQ-1:0]          req_write,
    input  logic [2*NUM_REQ-1:0]        req_size,
    input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
    input  logic [NUM_REQ*DATA_W-1:0]   req_wdata,
    output logic [NUM_REQ-1:0]          ack,
    output logic [DATA_W-1:0]           rdata
);
    logic [SLOT_W-1:0] phase;
    mem_cmd_t          cmds [NUM_REQ];
    logic              mem_en;
    mem_cmd_t          mem_cmd;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_unpack
        assign cmds[i].wr    = req_write[i];
        assign cmds[i].size  = acc_size_e'(req_size[2*i +: 2]);
        assign cmds[i].addr  = req_addr[i*ADDR_W +: ADDR_W];
        assign cmds[i].wdata = req_wdata[i*DATA_W +: DATA_W];
    end

    slot_rotor #(.PERIOD(PERIOD)) u_rotor (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    slot_picker #(.NUM_REQ(NUM_REQ), .SLOT_W(SLOT_W)) u_picker (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .req_valid (req_valid),
        .cmds      (cmds),
        .mem_en    (mem_en),
        .mem_cmd   (mem_cmd),
        .ack       (ack)
    );

    shared_ram #(.BYTES(BYTES)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .en    (mem_en),
        .cmd   (mem_cmd),
        .rdata (rdata)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> ack == '0);

endmodule

// File: tb/slot_mem_arbiter_test.sv
module slot_mem_arbiter_test;
    localparam int N  = 8;
    localparam int AW = 15;
    localparam int P  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_write = '0;
    logic [2*N-1:0]    req_size  = '0;
    logic [N*AW-1:0]   req_addr  = '0;
    logic [N*32-1:0]   req_wdata = '0;
    logic [N-1:0]      ack;
    logic [31:0]       rdata;

    slot_mem_arbiter uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata)
    );

    int edge_n = 0;
    always @(posedge clk) edge_n <= rst ? 0 : edge_n + 1;

    int errors = 0, checks = 0, multi_ack = 0;
    bit done = 0;
    always @(negedge clk) if (!rst && $countones(ack) > 1) multi_ack++;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(int i, int ph);
        return (((2 * i - ph) % P + P) % P) + 1;
    endfunction

    task automatic wait_phase(int ph);
        while (edge_n % P != ph) @(negedge clk);
    endtask

    task automatic access(int i, bit wr, bit [1:0] sz, bit [AW-1:0] a, bit [31:0] wd,
                          output int lat, output bit [31:0] rd, output int ph);
        ph = edge_n % P;
        req_write[i] = wr;
        req_size[2*i +: 2] = sz;
        req_addr[i*AW +: AW] = a;
        req_wdata[i*32 +: 32] = wd;
        req_valid[i] = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack[i] && lat < 40);
        rd = rdata;
        req_valid[i] = 1'b0;
    endtask

    task automatic txn(int i, bit wr, bit [1:0] sz, bit [AW-1:0] a, bit [31:0] wd,
                       bit [31:0] exp, string tag);
        int lat, ph;
        bit [31:0] rd;
        access(i, wr, sz, a, wd, lat, rd, ph);
        chk(lat == exp_lat(i, ph), {tag, " latency"}, lat, exp_lat(i, ph));
        if (!wr) chk(rd == exp, {tag, " data"}, rd, exp);
    endtask

    function automatic bit [31:0] pat(int i);
        return 32'hA5000000 ^ (32'h01010101 * (i + 1));
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lats [N];
        int phs [N];
        bit [31:0] rds [N];
        int alone, l1, p1, first;
        bit [31:0] r1;
        int hits [$];

        repeat (3) @(negedge clk);
        chk(ack == '0, "R1 ack low in reset", ack, 0);
        rst = 1'b0;
        // R1: first edge after reset is phase 0, so requester 0 is served at once
        txn(0, 1'b1, 2'd2, 15'h0000, 32'hCAFE0000, 0, "R1 first slot");

        // R2: each requester owns phase 2*i; write distinct patterns
        for (int i = 0; i < N; i++) begin
            wait_phase(0);
            access(i, 1'b1, 2'd2, AW'(16'h100 + 4 * i), pat(i), l1, r1, p1);
            chk(l1 == 2 * i + 1, "R2 slot latency from phase 0", l1, 2 * i + 1);
        end

        // R11: cross-requester readback
        for (int i = 0; i < N; i++)
            txn((i + 3) % N, 1'b0, 2'd2, AW'(16'h100 + 4 * i), 0, pat(i), "R11 shared read");

        // R7 R8 R9: sizes and lanes through requester 2
        txn(2, 1'b1, 2'd2, 15'h0200, 32'h11223344, 0, "R7 long write");
        txn(2, 1'b1, 2'd0, 15'h0202, 32'hFFFFFFAB, 0, "R9 byte write high bits");
        txn(2, 1'b0, 2'd2, 15'h0200, 0, 32'h11AB3344, "R7 byte lane only");
        txn(2, 1'b1, 2'd1, 15'h0201, 32'h5555BEEF, 0, "R8 word write odd addr");
        txn(2, 1'b0, 2'd3, 15'h0200, 0, 32'h11ABBEEF, "R8 word bit0 ignored");
        txn(4, 1'b0, 2'd0, 15'h0203, 0, 32'h00000011, "R9 byte read zero-ext");
        txn(5, 1'b0, 2'd1, 15'h0203, 0, 32'h000011AB, "R9 word read upper half");
        txn(6, 1'b0, 2'd2, 15'h0203, 0, 32'h11ABBEEF, "R8 long low bits ignored");
        txn(7, 1'b1, 2'd2, 15'h7FFF, 32'h0BADF00D, 0, "R8 top long write");
        txn(1, 1'b0, 2'd2, 15'h7FFC, 0, 32'h0BADF00D, "R8 top long read");
        txn(1, 1'b0, 2'd2, 15'h0200, 0, 32'h11ABBEEF, "R7 other long untouched");

        // R4 R3: every start phase, alone versus all eight busy
        for (int ph = 0; ph < P; ph++) begin
            wait_phase(ph);
            access(3, 1'b0, 2'd2, AW'(16'h10C), 0, alone, r1, p1);
            chk(alone == exp_lat(3, ph), "R2 phase sweep alone", alone, exp_lat(3, ph));
            chk(r1 == pat(3), "R11 sweep data", r1, pat(3));
            @(negedge clk);
            wait_phase(ph);
            for (int i = 0; i < N; i++) begin
                fork
                    automatic int k = i;
                    access(k, 1'b0, 2'd2, AW'(16'h100 + 4 * k), 0, lats[k], rds[k], phs[k]);
                join_none
            end
            wait fork;
            chk(lats[3] == alone, "R4 latency unchanged under load", lats[3], alone);
            for (int i = 0; i < N; i++) begin
                chk(lats[i] == exp_lat(i, ph), "R4 loaded latency", lats[i], exp_lat(i, ph));
                chk(rds[i] == pat(i), "R3 loaded data", rds[i], pat(i));
            end
        end
        chk(multi_ack == 0, "R3 one ack per cycle", multi_ack, 0);

        // R5: request raised just past own slot waits a whole rotation
        @(negedge clk);
        wait_phase(3);
        access(1, 1'b0, 2'd2, 15'h0104, 0, l1, r1, p1);
        chk(l1 == 16, "R5 idle slot not reused", l1, 16);

        // R6: fixed-length loop of one rotation
        @(negedge clk);
        wait_phase(6);
        first = -1;
        for (int it = 0; it < 4; it++) begin
            access(5, 1'b0, 2'd2, 15'h0114, 0, l1, r1, p1);
            if (first < 0) first = l1;
            chk(l1 == first && l1 == 5, "R6 repeatable latency", l1, 5);
            repeat (P - l1) @(negedge clk);
        end

        // R10: request held high for three rotations
        wait_phase(0);
        req_write[6] = 1'b0;
        req_size[12 +: 2] = 2'd2;
        req_addr[6*AW +: AW] = 15'h0118;
        req_valid[6] = 1'b1;
        for (int c = 1; c <= 48; c++) begin
            @(negedge clk);
            if (ack[6]) hits.push_back(c);
        end
        req_valid[6] = 1'b0;
        chk(hits.size() == 3, "R10 acks in three rotations", hits.size(), 3);
        if (hits.size() == 3) begin
            chk(hits[0] == 13, "R10 first ack", hits[0], 13);
            chk(hits[1] - hits[0] == 16, "R10 spacing", hits[1] - hits[0], 16);
            chk(hits[2] - hits[1] == 16, "R10 spacing", hits[2] - hits[1], 16);
        end

        repeat (2) @(negedge clk);
        chk(ack == '0, "R10 no ack after release", ack, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule